// File: doc/BRIEF.md
# Half-Bridge Command Conditioner with Deadtime

This block sits between a controller and the two gate drivers of one half-bridge leg. It takes a high-side and a low-side switching command and produces a gate-on enable for each side. It also produces a boost enable that drives an extra, stronger first drive stage for a short time after every turn-on. The commands are never passed straight through. When both commands are high, both sides are turned off. A side may turn on only after the opposite gate has been off for a programmable number of clock cycles. The two supply-undervoltage flags and the shutdown and freeze commands from a fault manager gate the result.

All asynchronous inputs go through the same synchronizer chain and then through one output register. Turn-on and turn-off latency is therefore the same number of cycles on both sides. Deadtime and boost length are counted in clock cycles, so a user converts the wanted durations using the clock rate. For example, at 100 MHz the defaults are 33 cycles (330 ns) and 20 cycles (200 ns).

Top module: `hb_gate_logic`

## Requirements
- R1: When both synchronized commands are high, both gate enables go low.
- R2: With only one command high, that side's gate follows it with a latency of SYNC_STAGES+1 clock edges, for both turn-on and turn-off and for both sides.
- R3: A gate rises exactly DEAD_CYC cycles after the opposite gate falls, and the two gate enables are never high in the same cycle.
- R4: Each rising gate enable starts a boost pulse on the same side that begins in the same cycle and lasts BOOST_CYC cycles. A boost enable is never high while its gate is low.
- R5: While the floating-supply flag `uv_float` is high, the high-side gate is held low and the low side keeps following its command.
- R6: After `uv_float` clears, the high-side gate stays low until a fresh rising edge on `cmd_hi`.
- R7: While the main-supply flag `uv_main` is high, both gates are low.
- R8: While `force_off` is high, both gates are low.
- R9: While `hold_out` is high and no shutdown is active, both gates keep their last value whatever the commands do. A shutdown (`force_off` or `uv_main`) overrides the hold.
- R10: During reset, both gates and both boost enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | High-side switching command (asynchronous) |
| cmd_lo | input | 1 | Low-side switching command (asynchronous) |
| uv_float | input | 1 | Floating (high-side) supply undervoltage, active high |
| uv_main | input | 1 | Main supply undervoltage, active high |
| force_off | input | 1 | Shutdown command from the fault manager, active high |
| hold_out | input | 1 | Freeze command from the fault manager, active high |
| gate_hi | output | 1 | High-side gate-on enable |
| gate_lo | output | 1 | Low-side gate-on enable |
| boost_hi | output | 1 | High-side first-stage boost enable |
| boost_lo | output | 1 | Low-side first-stage boost enable |

## Verification
The checker assumes that every input reaches the gate stage through exactly SYNC_STAGES synchronizer flops and one output flop. It keeps its own delay line of the shutdown and freeze inputs of that depth, so it holds only if the inputs are treated as ordinary sampled levels rather than as metastable edges. The stimulus changes inputs only on the falling clock edge and holds each pattern for far longer than the pipeline depth. This keeps every input level unambiguous at the next rising edge. The deadtime and boost counts are measured by the bench cycle by cycle, not by the checker.

// File: rtl/hb_pkg.sv
package hb_pkg;
   // index of each side inside the paired vectors
   localparam int SIDE_HI = 0;
   localparam int SIDE_LO = 1;
   localparam int NUM_SIDES = 2;

   typedef logic [NUM_SIDES-1:0] hb_pair_t;

   // synchronized input bundle, field order fixed for the synchronizer
   typedef struct packed {
      logic hi;
      logic lo;
      logic uvf;
      logic uvm;
      logic kill;
      logic hold;
   } hb_in_t;

   localparam int IN_W = $bits(hb_in_t);
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [STAGES-1:0][W-1:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain[0] <= din;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din};
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hb_request.sv
module hb_request
   import hb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  hb_in_t   s_in,
   output hb_pair_t req,
   output logic     freeze
);
   logic hi_prev;
   logic hi_blocked;
   logic hi_rise;
   logic hi_ok;
   logic kill_all;

   assign hi_rise  = s_in.hi & ~hi_prev;
   // high side allowed only when its supply is good and no stale lockout remains
   assign hi_ok    = ~s_in.uvf & (~hi_blocked | hi_rise);
   assign kill_all = s_in.kill | s_in.uvm;
   assign freeze   = s_in.hold & ~kill_all;

   always_comb begin
      req = '0;
      if (!kill_all) begin
         req[SIDE_HI] = s_in.hi & ~s_in.lo & hi_ok;
         req[SIDE_LO] = s_in.lo & ~s_in.hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_prev    <= 1'b0;
         hi_blocked <= 1'b0;
      end else begin
         hi_prev <= s_in.hi;
         if (s_in.uvf)     hi_blocked <= 1'b1;
         else if (hi_rise) hi_blocked <= 1'b0;
      end
   end
endmodule

// File: rtl/hb_side.sv
module hb_side #(
   parameter int DEAD_CYC  = 33,
   parameter int BOOST_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic freeze,
   input  logic peer_ready,
   output logic ready,
   output logic gate,
   output logic boost
);
   localparam int DW = $clog2(DEAD_CYC + 1);
   localparam int BW = $clog2(BOOST_CYC + 1);
   localparam logic [DW-1:0] DEAD_V  = DW'(DEAD_CYC);
   localparam logic [BW-1:0] BOOST_V = BW'(BOOST_CYC);

   logic          gate_q;
   logic          gate_nxt;
   logic [DW-1:0] off_cnt;
   logic [BW-1:0] boost_cnt;

   always_comb begin
      if (freeze) gate_nxt = gate_q;
      else        gate_nxt = req & (gate_q | peer_ready);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q    <= 1'b0;
         off_cnt   <= DEAD_V;
         boost_cnt <= '0;
      end else begin
         gate_q <= gate_nxt;
         if (gate_nxt)             off_cnt <= '0;
         else if (off_cnt != DEAD_V) off_cnt <= off_cnt + 1'b1;
         if (!gate_nxt)            boost_cnt <= '0;
         else if (!gate_q)         boost_cnt <= BOOST_V;
         else if (boost_cnt != '0) boost_cnt <= boost_cnt - 1'b1;
      end
   end

   assign ready = (off_cnt == DEAD_V);
   assign gate  = gate_q;
   assign boost = (boost_cnt != '0);
endmodule

// File: rtl/hb_gate_logic.sv
module hb_gate_logic
   import hb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEAD_CYC    = 33,
   parameter int BOOST_CYC   = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_hi,
   input  logic cmd_lo,
   input  logic uv_float,
   input  logic uv_main,
   input  logic force_off,
   input  logic hold_out,
   output logic gate_hi,
   output logic gate_lo,
   output logic boost_hi,
   output logic boost_lo
);
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hb_gate_logic: DEAD_CYC must be at least 1");
   end
   if (BOOST_CYC < 1) begin : g_bad_boost
      $error("hb_gate_logic: BOOST_CYC must be at least 1");
   end

   hb_in_t   raw_in;
   hb_in_t   s_in;
   hb_pair_t req;
   hb_pair_t ready;
   hb_pair_t gate;
   hb_pair_t boost;
   logic     freeze;

   assign raw_in = '{hi: cmd_hi, lo: cmd_lo, uvf: uv_float, uvm: uv_main,
                     kill: force_off, hold: hold_out};

   hb_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (s_in)
   );

   hb_request i_req (
      .clk   (clk),
      .rst_n (rst_n),
      .s_in  (s_in),
      .req   (req),
      .freeze(freeze)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      hb_side #(.DEAD_CYC(DEAD_CYC), .BOOST_CYC(BOOST_CYC)) i_side (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req[s]),
         .freeze    (freeze),
         .peer_ready(ready[NUM_SIDES-1-s]),
         .ready     (ready[s]),
         .gate      (gate[s]),
         .boost     (boost[s])
      );
   end

   assign gate_hi  = gate[SIDE_HI];
   assign gate_lo  = gate[SIDE_LO];
   assign boost_hi = boost[SIDE_HI];
   assign boost_lo = boost[SIDE_LO];
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic uv_main,
   input logic force_off,
   input logic hold_out,
   input logic gate_hi,
   input logic gate_lo,
   input logic boost_hi,
   input logic boost_lo
);
   // delay lines matching the synchronizer plus output register
   logic [SYNC_STAGES:0] kill_dl;
   logic [SYNC_STAGES:0] hold_dl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kill_dl <= '0;
         hold_dl <= '0;
      end else begin
         kill_dl <= {kill_dl[SYNC_STAGES-1:0], force_off | uv_main};
         hold_dl <= {hold_dl[SYNC_STAGES-1:0], hold_out};
      end
   end

   p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   p_boost_in_gate_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      boost_hi |-> gate_hi);

   p_boost_in_gate_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      boost_lo |-> gate_lo);

   p_boost_start_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> boost_hi);

   p_boost_start_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> boost_lo);

   // R7 and R8: any shutdown source clears both gates
   p_kill_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      kill_dl[SYNC_STAGES] |-> (!gate_hi && !gate_lo));

   p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_dl[SYNC_STAGES] && !kill_dl[SYNC_STAGES]) |->
         ($stable(gate_hi) && $stable(gate_lo)));
endmodule

bind hb_gate_logic hb_gate_chk #(.SYNC_STAGES(SYNC_STAGES)) i_hb_gate_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .uv_main  (uv_main),
   .force_off(force_off),
   .hold_out (hold_out),
   .gate_hi  (gate_hi),
   .gate_lo  (gate_lo),
   .boost_hi (boost_hi),
   .boost_lo (boost_lo)
);

// File: tb/test_hb_gate_logic.sv
module test_hb_gate_logic;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC  = 2;
   localparam int DEAD  = 4;
   localparam int BOOST = 3;
   localparam int LAT   = SYNC + 1;
   localparam int SETTLE = 12;
   localparam int NROWS = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_hi = 0, cmd_lo = 0, uv_float = 0, uv_main = 0, force_off = 0, hold_out = 0;
   logic gate_hi, gate_lo, boost_hi, boost_lo;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hb_gate_logic #(.SYNC_STAGES(SYNC), .DEAD_CYC(DEAD), .BOOST_CYC(BOOST)) i_hb_gate_logic (
      .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .uv_float(uv_float), .uv_main(uv_main), .force_off(force_off),
      .hold_out(hold_out), .gate_hi(gate_hi), .gate_lo(gate_lo),
      .boost_hi(boost_hi), .boost_lo(boost_lo)
   );

   // {tag[3:0], hi, lo, uvf, uvm, kill, hold, exp_hi, exp_lo}
   localparam logic [11:0] VEC [NROWS] = '{
      12'b0010_000000_00, // R2 idle
      12'b0010_100000_10, // R2 high only
      12'b0010_010000_01, // R2 low only
      12'b0001_110000_00, // R1 both high
      12'b0010_100000_10, // R2 high only
      12'b1001_010001_10, // R9 hold keeps high on
      12'b1001_010000_01, // R9 release
      12'b1001_010011_00, // R9 shutdown beats hold
      12'b1000_010010_00, // R8 shutdown
      12'b1000_010000_01, // R8 recovery
      12'b0111_010100_00, // R7 main undervoltage
      12'b0101_101000_00, // R5 floating undervoltage blocks high
      12'b0101_011000_01, // R5 low side unaffected
      12'b0110_101000_00, // R6 edge during undervoltage
      12'b0110_100000_00, // R6 no fresh edge, stays off
      12'b0110_000000_00, // R6 command low
      12'b0110_100000_10, // R6 fresh edge turns on
      12'b0001_110000_00  // R1 both high from high on
   };

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] v);
      {cmd_hi, cmd_lo, uv_float, uv_main, force_off, hold_out} = v;
   endtask

   // drive a command pair and record transition cycle indices
   task automatic measure(input logic hi, input logic lo,
                          output int hr, output int hf, output int lr, output int lf,
                          output int nbh, output int nbl, output int fbh, output int fbl,
                          output int ovl);
      logic ph, pl;
      ph = gate_hi; pl = gate_lo;
      hr = -1; hf = -1; lr = -1; lf = -1; nbh = 0; nbl = 0; fbh = -1; fbl = -1; ovl = 0;
      cmd_hi = hi; cmd_lo = lo;
      for (int i = 1; i <= 20; i++) begin
         @(posedge clk); @(negedge clk);
         if (gate_hi && !ph && hr < 0) hr = i;
         if (!gate_hi && ph && hf < 0) hf = i;
         if (gate_lo && !pl && lr < 0) lr = i;
         if (!gate_lo && pl && lf < 0) lf = i;
         if (boost_hi) begin nbh++; if (fbh < 0) fbh = i; end
         if (boost_lo) begin nbl++; if (fbl < 0) fbl = i; end
         if (gate_hi && gate_lo) ovl = 1;
         ph = gate_hi; pl = gate_lo;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R2 actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int hr, hf, lr, lf, nbh, nbl, fbh, fbl, ovl;
      cmd_hi = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      check(gate_hi == 0 && gate_lo == 0, "R10", "gates in reset", {gate_hi, gate_lo}, 0);
      check(boost_hi == 0 && boost_lo == 0, "R10", "boosts in reset", {boost_hi, boost_lo}, 0);
      cmd_hi = 1'b0;
      rst_n = 1'b1;
      repeat (SETTLE) @(negedge clk);

      for (int r = 0; r < NROWS; r++) begin
         drive(VEC[r][7:2]);
         repeat (SETTLE) @(negedge clk);
         checks++;
         if ({gate_hi, gate_lo} != VEC[r][1:0]) begin
            errors++;
            $display("FAIL R%0d row %0d actual %b%b expected %b", VEC[r][11:8], r,
                     gate_hi, gate_lo, VEC[r][1:0]);
         end
      end

      drive(6'b000000);
      repeat (SETTLE) @(negedge clk);
      measure(1, 0, hr, hf, lr, lf, nbh, nbl, fbh, fbl, ovl);
      check(hr == LAT, "R2", "high turn-on latency", hr, LAT);
      check(nbh == BOOST, "R4", "high boost length", nbh, BOOST);
      check(fbh == hr, "R4", "high boost start", fbh, hr);

      measure(0, 1, hr, hf, lr, lf, nbh, nbl, fbh, fbl, ovl);
      check(hf == LAT, "R2", "high turn-off latency", hf, LAT);
      check(lr - hf == DEAD, "R3", "deadtime before low", lr - hf, DEAD);
      check(ovl == 0, "R3", "overlap", ovl, 0);
      check(nbl == BOOST, "R4", "low boost length", nbl, BOOST);
      check(fbl == lr, "R4", "low boost start", fbl, lr);

      measure(0, 0, hr, hf, lr, lf, nbh, nbl, fbh, fbl, ovl);
      check(lf == LAT, "R2", "low turn-off latency", lf, LAT);

      measure(0, 1, hr, hf, lr, lf, nbh, nbl, fbh, fbl, ovl);
      check(lr == LAT, "R2", "low turn-on latency", lr, LAT);

      measure(1, 0, hr, hf, lr, lf, nbh, nbl, fbh, fbl, ovl);
      check(lf == LAT, "R2", "low off before high", lf, LAT);
      check(hr - lf == DEAD, "R3", "deadtime before high", hr - lf, DEAD);
      check(ovl == 0, "R3", "overlap", ovl, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule